// File: doc/BRIEF.md
# Interleaved Hardware-Thread Issue Selector

This block sits at the front of a barrel-style multithreaded pipeline and decides which hardware thread owns each issue slot. It keeps one program counter per thread. Each cycle it presents one slot on its output: a thread tag, that thread's program counter, and a valid flag. The tag travels down the pipeline with the instruction, so later stages use it to index the correct per-thread register copy. Slots belong to threads. When the owning thread is not ready, the slot goes out as a bubble (valid low, tag still set to the owner) and is never handed to another thread.

Two schedules are available. In rotation mode, thread 0, 1, ... N-1 each get one slot in turn. In table mode, a small programmable table of thread tags is walked cyclically over a programmable number of entries, so software can weight threads unequally. Table writes, the length setting and the mode setting are all staged and only take effect when the current schedule pass completes. A pass in progress is therefore never torn.

The output is a valid/ready stream. A valid slot that is not accepted holds every output field steady and consumes nothing. A bubble needs no acceptance: it moves on every cycle, whatever the ready input says. Within one thread, program counters step by exactly one per issued instruction.

Top module: `thread_select`

## Requirements
- R1: While reset is asserted, `iss_valid` is 0 and every thread's program counter loads its slice of `rst_vec` (thread t uses bits [t*PC_W +: PC_W]). The first slot presented after reset comes from schedule position 0, which is thread 0 in rotation mode.
- R2: In rotation mode (`cfg_mode` = 0), consecutive slots carry thread tags 0, 1, ..., NUM_THREADS-1 and then repeat, so every thread owns exactly one of any NUM_THREADS consecutive slots.
- R3: When the owning thread's `thr_ready` bit is 0 at the moment its slot is selected, that slot is presented with `iss_valid` = 0 and `iss_tid` equal to the owner. No other thread issues in it.
- R4: `iss_pc` is always the program counter of the thread named by `iss_tid`.
- R5: A thread's program counter increases by exactly one each time that thread issues a valid slot. It is unchanged by bubbles and by stalled cycles.
- R6: In table mode (`cfg_mode` = 1), slots carry the thread tags stored in table entries 0 .. L-1 in order, then repeat, where L is the active length.
- R7: The active length is `cfg_len` limited to the range 1 .. TABLE_DEPTH: a value of 0 acts as 1, and a value above TABLE_DEPTH acts as TABLE_DEPTH.
- R8: Table writes (`tbl_wr_en`, `tbl_wr_idx`, `tbl_wr_tid`), `cfg_len` and `cfg_mode` affect the schedule only from the first slot after the current pass ends. A write made in the same cycle as the last slot of a pass waits for the following pass.
- R9: While `iss_valid` = 1 and `iss_ready` = 0, `iss_valid`, `iss_tid` and `iss_pc` hold their values on the next cycle, and no slot is consumed.
- R10: A bubble (`iss_valid` = 0) is replaced by the next slot on the following cycle, even when `iss_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Schedule mode request: 0 rotation, 1 table (applied at pass end) |
| cfg_len | input | $clog2(TABLE_DEPTH)+1 | Requested table length (applied at pass end, limited to 1..TABLE_DEPTH) |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | $clog2(TABLE_DEPTH) | Table entry index to write |
| tbl_wr_tid | input | $clog2(NUM_THREADS) | Thread tag to store in the entry |
| thr_ready | input | NUM_THREADS | Per-thread ready flags, sampled when a slot is selected |
| rst_vec | input | NUM_THREADS*PC_W | Per-thread reset program counters, thread t at [t*PC_W +: PC_W] |
| iss_valid | output | 1 | Current slot carries an instruction (0 = bubble) |
| iss_ready | input | 1 | Downstream accepts the current valid slot |
| iss_tid | output | $clog2(NUM_THREADS) | Thread owning the current slot |
| iss_pc | output | PC_W | Program counter of the owning thread |

## Verification
The bench targets ownership of bubbles. A selector that gave an unready thread's slot to a neighbour would show the wrong tag, or would show an extra valid slot for another thread. Staging is tested by writing table entries and changing mode and length while a pass is still running. A design that applied them at once would produce a tag order that departs from the reference within the same pass. Length limits are driven with 0 and with a value above the table depth: a missing clamp either stalls on a zero-length walk or reads entries beyond the table. Back-pressure and bubbles are mixed to make sure that stalled valid slots freeze the program counter and that bubbles never wait for acceptance.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic {
    SCHED_ROTATE = 1'b0,
    SCHED_TABLE  = 1'b1
  } sched_mode_e;

  // Limit a requested walk length to 1..depth.
  function automatic int unsigned fit_len(input int unsigned req, input int unsigned depth);
    if (req == 0) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

endpackage

// File: rtl/ts_slot_seq.sv
module ts_slot_seq #(
  parameter int NUM_THREADS = 4,
  parameter int TABLE_DEPTH = 8,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int PTR_W = $clog2(TABLE_DEPTH),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             cfg_mode,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [TID_W-1:0] wr_tid,
  output logic [TID_W-1:0] owner,
  output logic             tbl_mode
);
  import ts_pkg::*;

  sched_mode_e      act_mode;
  logic [LEN_W-1:0] act_len;
  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] last_idx;
  logic             at_end;
  logic             roll;
  logic [TID_W-1:0] act_tids [TABLE_DEPTH];

  always_comb begin
    if (act_mode == SCHED_TABLE) last_idx = act_len - LEN_W'(1);
    else                         last_idx = LEN_W'(NUM_THREADS - 1);
  end

  assign at_end = ({1'b0, ptr_q} == last_idx);
  assign roll   = adv && at_end;

  // Staged (pending) and live copy of each table entry.
  for (genvar e = 0; e < TABLE_DEPTH; e++) begin : g_entry
    logic [TID_W-1:0] pend_r;
    logic [TID_W-1:0] live_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= TID_W'(e % NUM_THREADS);
        live_r <= TID_W'(e % NUM_THREADS);
      end else begin
        if (wr_en && (wr_idx == PTR_W'(e))) pend_r <= wr_tid;
        if (roll) live_r <= pend_r;
      end
    end
    assign act_tids[e] = live_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      act_mode <= SCHED_ROTATE;
      act_len  <= LEN_W'(TABLE_DEPTH);
    end else if (adv) begin
      if (at_end) begin
        ptr_q    <= '0;
        act_mode <= sched_mode_e'(cfg_mode);
        act_len  <= LEN_W'(fit_len(int'(cfg_len), TABLE_DEPTH));
      end else begin
        ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end

  assign owner    = (act_mode == SCHED_TABLE) ? act_tids[ptr_q] : ptr_q[TID_W-1:0];
  assign tbl_mode = (act_mode == SCHED_TABLE);

endmodule

// File: rtl/ts_pc_bank.sv
module ts_pc_bank #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_THREADS*PC_W-1:0] rst_vec,
  input  logic                        step_en,
  input  logic [TID_W-1:0]            step_tid,
  input  logic [TID_W-1:0]            rd_tid,
  output logic [PC_W-1:0]             rd_pc
);
  logic [PC_W-1:0] pc_arr [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [PC_W-1:0] pc_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   pc_r <= rst_vec[t*PC_W +: PC_W];
      else if (step_en && (step_tid == TID_W'(t)))  pc_r <= pc_r + PC_W'(1);
    end
    assign pc_arr[t] = pc_r;
  end

  assign rd_pc = pc_arr[rd_tid];

endmodule

// File: rtl/ts_issue_reg.sv
module ts_issue_reg #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [TID_W-1:0] in_tid,
  input  logic [PC_W-1:0]  in_pc,
  output logic             out_valid,
  output logic [TID_W-1:0] out_tid,
  output logic [PC_W-1:0]  out_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tid   <= '0;
      out_pc    <= '0;
    end else if (adv) begin
      out_valid <= in_valid;
      out_tid   <= in_tid;
      out_pc    <= in_pc;
    end
  end
endmodule

// File: rtl/thread_select.sv
module thread_select #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int TABLE_DEPTH = 8,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int PTR_W = $clog2(TABLE_DEPTH),
  localparam int LEN_W = PTR_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_mode,
  input  logic [LEN_W-1:0]            cfg_len,
  input  logic                        tbl_wr_en,
  input  logic [PTR_W-1:0]            tbl_wr_idx,
  input  logic [TID_W-1:0]            tbl_wr_tid,
  input  logic [NUM_THREADS-1:0]      thr_ready,
  input  logic [NUM_THREADS*PC_W-1:0] rst_vec,
  output logic                        iss_valid,
  input  logic                        iss_ready,
  output logic [TID_W-1:0]            iss_tid,
  output logic [PC_W-1:0]             iss_pc
);
  logic             adv;
  logic [TID_W-1:0] sel_owner;
  logic             sel_ready;
  logic [PC_W-1:0]  sel_pc;
  logic             seq_tbl_mode;

  // Output stage moves when empty (bubble) or accepted.
  assign adv       = !iss_valid || iss_ready;
  assign sel_ready = thr_ready[sel_owner];

  ts_slot_seq #(
    .NUM_THREADS(NUM_THREADS),
    .TABLE_DEPTH(TABLE_DEPTH)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .cfg_mode (cfg_mode),
    .cfg_len  (cfg_len),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_tid   (tbl_wr_tid),
    .owner    (sel_owner),
    .tbl_mode (seq_tbl_mode)
  );

  ts_pc_bank #(
    .NUM_THREADS(NUM_THREADS),
    .PC_W       (PC_W)
  ) u_pcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_vec  (rst_vec),
    .step_en  (adv && sel_ready),
    .step_tid (sel_owner),
    .rd_tid   (sel_owner),
    .rd_pc    (sel_pc)
  );

  ts_issue_reg #(
    .NUM_THREADS(NUM_THREADS),
    .PC_W       (PC_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (sel_ready),
    .in_tid    (sel_owner),
    .in_pc     (sel_pc),
    .out_valid (iss_valid),
    .out_tid   (iss_tid),
    .out_pc    (iss_pc)
  );

endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iss_valid,
  input logic                   iss_ready,
  input logic [TID_W-1:0]       iss_tid,
  input logic [PC_W-1:0]        iss_pc,
  input logic [NUM_THREADS-1:0] thr_ready,
  input logic [TID_W-1:0]       sel_owner,
  input logic                   seq_tbl_mode
);
  logic                   moving;
  logic                   started;
  logic                   slot_tbl;
  logic [NUM_THREADS-1:0] seen;
  logic [PC_W-1:0]        last_pc [NUM_THREADS];

  assign moving = !iss_valid || iss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      slot_tbl <= 1'b0;
      seen     <= '0;
      for (int t = 0; t < NUM_THREADS; t++) last_pc[t] <= '0;
    end else begin
      if (moving) begin
        started  <= 1'b1;
        slot_tbl <= seq_tbl_mode;
      end
      if (iss_valid && iss_ready) begin
        seen[iss_tid]    <= 1'b1;
        last_pc[iss_tid] <= iss_pc;
      end
    end
  end

  // R1: first cycle out of reset shows no instruction
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !iss_valid);

  // R2: rotation mode steps the tag by one inside a pass
  p_rotate_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && moving && !slot_tbl && (iss_tid != TID_W'(NUM_THREADS - 1)))
      |=> (iss_tid == $past(iss_tid) + TID_W'(1)));

  // R3: valid flag follows the owner's ready at selection time
  p_bubble_when_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    moving |=> (iss_valid == $past(thr_ready[sel_owner])));

  // R5: each issue of a thread carries its previous PC plus one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && seen[iss_tid]) |-> (iss_pc == last_pc[iss_tid] + PC_W'(1)));

  // R9: stalled valid slot is frozen
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_tid) && $stable(iss_pc)));

endmodule

bind thread_select ts_checker #(
  .NUM_THREADS(NUM_THREADS),
  .PC_W       (PC_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_valid    (iss_valid),
  .iss_ready    (iss_ready),
  .iss_tid      (iss_tid),
  .iss_pc       (iss_pc),
  .thr_ready    (thr_ready),
  .sel_owner    (sel_owner),
  .seq_tbl_mode (seq_tbl_mode)
);

// File: tb/thread_select_tb_top.sv
`timescale 1ns/1ps
module thread_select_tb_top;
  localparam int NT    = 4;
  localparam int PCW   = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_mode;
  logic [3:0]       cfg_len;
  logic             tbl_wr_en;
  logic [2:0]       tbl_wr_idx;
  logic [1:0]       tbl_wr_tid;
  logic [NT-1:0]    thr_ready;
  logic [NT*PCW-1:0] rst_vec;
  logic             iss_valid;
  logic             iss_ready;
  logic [1:0]       iss_tid;
  logic [PCW-1:0]   iss_pc;

  always #2.5 clk = ~clk;

  thread_select #(.NUM_THREADS(NT), .PC_W(PCW), .TABLE_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_tid(tbl_wr_tid),
    .thr_ready(thr_ready), .rst_vec(rst_vec), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_tid(iss_tid), .iss_pc(iss_pc)
  );

  int    total = 0;
  int    fails = 0;
  bit    done  = 0;
  bit    cmp_on = 0;
  bit    log_on = 0;
  string cur_req = "R2";
  int    tq[$];
  bit    vq[$];

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int count_slots(input int tid, input bit vld);
    int n = 0;
    foreach (tq[i]) if (tq[i] == tid && vq[i] == vld) n++;
    return n;
  endfunction

  task automatic run(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Behavioural reference
  int          m_ptr, m_len, m_act[DEPTH], m_pend[DEPTH];
  bit          m_mode;
  logic [31:0] m_pc[NT];
  bit          e_valid;
  int          e_tid;
  logic [31:0] e_pc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_mode = 0; m_len = DEPTH;
      for (int i = 0; i < DEPTH; i++) begin m_act[i] = i % NT; m_pend[i] = i % NT; end
      for (int t = 0; t < NT; t++) m_pc[t] = 32'h1000 * (t + 1);
      e_valid = 0; e_tid = 0; e_pc = 0;
    end else begin
      int own;
      int last;
      if (!e_valid || iss_ready) begin
        own = m_mode ? m_act[m_ptr] : m_ptr;
        e_valid = thr_ready[own];
        e_tid = own;
        e_pc = m_pc[own];
        if (thr_ready[own]) m_pc[own] = m_pc[own] + 1;
        last = m_mode ? m_len - 1 : NT - 1;
        if (m_ptr == last) begin
          m_ptr = 0;
          m_mode = cfg_mode;
          m_len = (cfg_len == 0) ? 1 : ((int'(cfg_len) > DEPTH) ? DEPTH : int'(cfg_len));
          for (int i = 0; i < DEPTH; i++) m_act[i] = m_pend[i];
        end else begin
          m_ptr++;
        end
      end
      if (tbl_wr_en) m_pend[tbl_wr_idx] = tbl_wr_tid;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(cur_req, iss_valid, e_valid);
      check(cur_req, iss_tid, e_tid);
      if (e_valid) check("R5", iss_pc, e_pc);
    end
    if (rst_n && log_on && (!iss_valid || iss_ready)) begin
      tq.push_back(iss_tid);
      vq.push_back(iss_valid);
    end
  end

  task automatic clear_log();
    tq.delete();
    vq.delete();
    log_on = 1;
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [1:0]  h_tid;
    logic [31:0] h_pc;
    for (int t = 0; t < NT; t++) rst_vec[t*PCW +: PCW] = 32'h1000 * (t + 1);
    rst_n = 0; cfg_mode = 0; cfg_len = 4'd8; tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_tid = 0;
    thr_ready = '1; iss_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", iss_valid, 0);
    cmp_on = 1;
    @(negedge clk);
    check("R1", iss_valid, 1);
    check("R1", iss_tid, 0);
    check("R4", iss_pc, 32'h1000);

    // Rotation, everyone ready
    run(1); cur_req = "R2"; clear_log(); run(8);
    for (int t = 0; t < NT; t++) check("R2", count_slots(t, 1), 2);
    check("R4", iss_pc[31:12], iss_tid + 1);

    // Thread 2 not ready: its slots become bubbles
    thr_ready = 4'b1011; run(1); cur_req = "R3"; clear_log(); run(8);
    check("R3", count_slots(2, 1), 0);
    check("R3", count_slots(2, 0), 2);
    check("R3", count_slots(0, 1) + count_slots(1, 1) + count_slots(3, 1), 6);

    // Back-pressure holds a valid slot
    thr_ready = '1; run(2); cur_req = "R9"; iss_ready = 0; run(2);
    h_tid = iss_tid; h_pc = iss_pc;
    run(4);
    check("R9", iss_valid, 1);
    check("R9", iss_tid, h_tid);
    check("R9", iss_pc, h_pc);
    iss_ready = 1;

    // Bubbles drain without acceptance
    thr_ready = '0; run(1); iss_ready = 0; cur_req = "R10"; run(1); clear_log(); run(8);
    for (int t = 0; t < NT; t++) check("R10", count_slots(t, 0), 2);
    iss_ready = 1; thr_ready = '1; run(2);

    // Table writes staged while rotation continues
    cur_req = "R8";
    for (int i = 0; i < 6; i++) begin
      tbl_wr_en = 1; tbl_wr_idx = 3'(i); tbl_wr_tid = 2'((i % 2 == 0) ? 0 : (i + 1) / 2);
      run(1);
    end
    tbl_wr_en = 0; cfg_len = 4'd6; cfg_mode = 1;
    run(6); cur_req = "R6"; clear_log(); run(12);
    check("R6", count_slots(0, 1), 6);
    for (int t = 1; t < NT; t++) check("R6", count_slots(t, 1), 2);

    // Mid-pass rewrite of entry 1 to thread 3
    cur_req = "R8";
    tbl_wr_en = 1; tbl_wr_idx = 3'd1; tbl_wr_tid = 2'd3; run(1); tbl_wr_en = 0;
    run(8); clear_log(); run(12);
    check("R8", count_slots(3, 1), 4);
    check("R8", count_slots(1, 1), 0);

    // Length limits
    cur_req = "R7"; cfg_len = 4'd0; run(10); clear_log(); run(6);
    check("R7", count_slots(0, 1), 6);
    cfg_len = 4'd15; run(10); clear_log(); run(16);
    check("R7", count_slots(0, 1), 6);
    check("R7", count_slots(3, 1), 6);
    check("R7", count_slots(2, 1), 4);

    // Back to rotation
    cfg_mode = 0; run(12); cur_req = "R2"; clear_log(); run(8);
    for (int t = 0; t < NT; t++) check("R2", count_slots(t, 1), 2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule